// File: doc/BRIEF.md
# Eight-bit ALU with Flag and Mask Register

This block combines an 8-bit arithmetic and logic unit with the condition-code register that records what the last operation produced. Each cycle in which `op_valid` is high, the unit combines the accumulator operand with a second operand according to `op_code`. It presents the 8-bit result on `res_out`, together with a write-back enable for the accumulator. On the following clock edge it updates the flags: half carry, negative, zero and carry. Each flag follows its own rule about which operations may touch it.

The same register holds a two-bit interrupt mask. The mask bits sit at non-adjacent positions. A narrow write path changes only the mask bits. A full-width write path replaces the whole register, as restoring it from a stack would. The register is always readable in full, as saving it to a stack would read it. Four branch-test outputs expose the half-carry and sign flags directly to the sequencer that decides conditional jumps.

Top module: `alu_ccr_top`

## Requirements
- R1: After reset the register reads 8'hE8: bits 7, 6, 5 (I1) and 3 (I0) are one, and H, N, Z and C are zero.
- R2: Register layout, from bit 7 down to bit 0, is 1, 1, I1, H, I0, N, Z, C. Bits 7 and 6 always read one. A cycle with `cc_we` high loads `cc_wdata[5:0]` into bits 5:0 on the next edge. This full write takes priority over any flag or mask update in the same cycle.
- R3: `op_code` encodings are 0 add, 1 add-with-carry (adds C), 2 subtract, 3 subtract-with-carry (subtracts C), 4 AND, 5 OR, 6 XOR, 7 load (result is the second operand), 8 compare. `res_out` is the 8-bit result in the same cycle. Codes 9 to 15 are no operation.
- R4: Add and add-with-carry set H when a carry passes from bit 3 into bit 4, and clear it otherwise.
- R5: Every operation other than add and add-with-carry leaves H unchanged.
- R6: Opcodes 0 to 8 set N to bit 7 of the result.
- R7: Opcodes 0 to 8 set Z when the 8-bit result is zero and clear it otherwise.
- R8: C takes the carry out of bit 7 on add and add-with-carry. It takes the borrow on subtract, subtract-with-carry and compare. AND, OR, XOR and load leave C unchanged.
- R9: `res_we` is high for opcodes 0 to 7 while `op_valid` is high. It is low for compare and for no-operation codes, although compare still updates N, Z and C.
- R10: When `mask_we` is high and `cc_we` is low, `mask_wdata[1]` is written to I1 and `mask_wdata[0]` to I0 on the next edge. All other bits are untouched, and any flag update from a concurrent operation still applies.
- R11: `br_h_set` and `br_h_clr` reflect H being one and zero. `br_minus` and `br_plus` reflect N being one and zero. All four are driven combinationally from the stored register.
- R12: With `op_valid` low, or with a no-operation code, no flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Execute `op_code` this cycle |
| op_code | input | 4 | Operation select |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second operand |
| res_out | output | 8 | Combinational result |
| res_we | output | 1 | Accumulator write-back enable |
| cc_we | input | 1 | Full register write strobe |
| cc_wdata | input | 8 | Full register write data |
| mask_we | input | 1 | Interrupt-mask write strobe |
| mask_wdata | input | 2 | New {I1, I0} |
| cc_out | output | 8 | Register contents |
| br_h_set | output | 1 | H is one |
| br_h_clr | output | 1 | H is zero |
| br_minus | output | 1 | N is one |
| br_plus | output | 1 | N is zero |

## Verification
The assertions assume that the sequencer holds `op_code`, the operands and the write strobes steady across each clock edge. They also assume that a full register write comes from one source at a time. The flag properties are therefore conditioned on `cc_we` being low, so that the register's priority rule never makes them ambiguous. The stimulus changes every input only on the falling edge. It presets the flags with a full write in its own cycle before each operation. This means the carry consumed by add-with-carry and subtract-with-carry is always known to the sweep.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;
    localparam int DW      = 8;
    localparam int NIB     = 4;
    localparam int CC_C    = 0;
    localparam int CC_Z    = 1;
    localparam int CC_N    = 2;
    localparam int CC_I0   = 3;
    localparam int CC_H    = 4;
    localparam int CC_I1   = 5;
    localparam logic [7:0] CC_RESET = 8'hE8;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBC = 4'd3,
        OP_AND = 4'd4, OP_OR  = 4'd5, OP_XOR = 4'd6, OP_LD  = 4'd7,
        OP_CP  = 4'd8
    } alu_op_e;

    typedef struct packed {
        logic h_upd;
        logic nz_upd;
        logic c_upd;
        logic h;
        logic n;
        logic z;
        logic c;
    } flag_upd_t;

    typedef struct packed {
        logic i1;
        logic h;
        logic i0;
        logic n;
        logic z;
        logic c;
    } cc_state_t;
endpackage

// File: rtl/alu_core.sv
module alu_core
    import alu_cc_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         valid,
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         wb,
    output flag_upd_t    upd
);
    logic [W:0]     sum_w;
    logic [W:0]     dif_w;
    logic [NIB:0]   nib_w;
    logic           use_c;
    logic           is_add;
    logic           is_sub;

    always_comb begin
        is_add = (op == OP_ADD) || (op == OP_ADC);
        is_sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CP);
        use_c  = (op == OP_ADC) || (op == OP_SBC);
        sum_w  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, use_c & cin};
        dif_w  = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, use_c & cin};
        nib_w  = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, use_c & cin};

        res = '0;
        wb  = 1'b0;
        upd = '0;
        if (valid) begin
            case (op)
                OP_ADD, OP_ADC:        res = sum_w[W-1:0];
                OP_SUB, OP_SBC, OP_CP: res = dif_w[W-1:0];
                OP_AND:                res = a & b;
                OP_OR:                 res = a | b;
                OP_XOR:                res = a ^ b;
                OP_LD:                 res = b;
                default:               res = '0;
            endcase
            if (op <= OP_CP) begin
                upd.nz_upd = 1'b1;
                upd.n      = res[W-1];
                upd.z      = (res == '0);
                wb         = (op != OP_CP);
            end
            if (is_add) begin
                upd.h_upd = 1'b1;
                upd.h     = nib_w[NIB];
                upd.c_upd = 1'b1;
                upd.c     = sum_w[W];
            end
            if (is_sub) begin
                upd.c_upd = 1'b1;
                upd.c     = dif_w[W];
            end
        end
    end
endmodule

// File: rtl/cc_reg.sv
module cc_reg
    import alu_cc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  flag_upd_t  upd,
    input  logic       cc_we,
    input  logic [7:0] cc_wdata,
    input  logic       mask_we,
    input  logic [1:0] mask_wdata,
    output logic [7:0] cc_out
);
    cc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cc_we) begin
            st_d.i1 = cc_wdata[CC_I1];
            st_d.h  = cc_wdata[CC_H];
            st_d.i0 = cc_wdata[CC_I0];
            st_d.n  = cc_wdata[CC_N];
            st_d.z  = cc_wdata[CC_Z];
            st_d.c  = cc_wdata[CC_C];
        end else begin
            if (mask_we) begin
                st_d.i1 = mask_wdata[1];
                st_d.i0 = mask_wdata[0];
            end
            if (upd.h_upd) st_d.h = upd.h;
            if (upd.nz_upd) begin
                st_d.n = upd.n;
                st_d.z = upd.z;
            end
            if (upd.c_upd) st_d.c = upd.c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{i1: CC_RESET[CC_I1], h: CC_RESET[CC_H], i0: CC_RESET[CC_I0],
                      n: CC_RESET[CC_N], z: CC_RESET[CC_Z], c: CC_RESET[CC_C]};
        end else begin
            st_q <= st_d;
        end
    end

    assign cc_out = {2'b11, st_q.i1, st_q.h, st_q.i0, st_q.n, st_q.z, st_q.c};
endmodule

// File: rtl/branch_tests.sv
module branch_tests
    import alu_cc_pkg::*;
(
    input  logic [7:0] cc,
    output logic       h_set,
    output logic       h_clr,
    output logic       minus,
    output logic       plus
);
    always_comb begin
        h_set = cc[CC_H];
        h_clr = ~cc[CC_H];
        minus = cc[CC_N];
        plus  = ~cc[CC_N];
    end
endmodule

// File: rtl/alu_ccr_top.sv
module alu_ccr_top
    import alu_cc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_valid,
    input  logic [3:0] op_code,
    input  logic [7:0] acc_in,
    input  logic [7:0] opnd_in,
    output logic [7:0] res_out,
    output logic       res_we,
    input  logic       cc_we,
    input  logic [7:0] cc_wdata,
    input  logic       mask_we,
    input  logic [1:0] mask_wdata,
    output logic [7:0] cc_out,
    output logic       br_h_set,
    output logic       br_h_clr,
    output logic       br_minus,
    output logic       br_plus
);
    flag_upd_t upd;

    alu_core #(.W(DW)) u_core (
        .valid (op_valid),
        .op    (op_code),
        .a     (acc_in),
        .b     (opnd_in),
        .cin   (cc_out[CC_C]),
        .res   (res_out),
        .wb    (res_we),
        .upd   (upd)
    );

    cc_reg u_cc (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd        (upd),
        .cc_we      (cc_we),
        .cc_wdata   (cc_wdata),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .cc_out     (cc_out)
    );

    branch_tests u_br (
        .cc    (cc_out),
        .h_set (br_h_set),
        .h_clr (br_h_clr),
        .minus (br_minus),
        .plus  (br_plus)
    );
endmodule

// File: rtl/alu_ccr_chk.sv
module alu_ccr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_valid,
    input logic [3:0] op_code,
    input logic [7:0] res_out,
    input logic       cc_we,
    input logic [7:0] cc_wdata,
    input logic       mask_we,
    input logic [1:0] mask_wdata,
    input logic [7:0] cc_out
);
    logic fire;
    assign fire = op_valid && (op_code <= 4'd8) && !cc_we;

    p_full_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cc_we |=> cc_out == ($past(cc_wdata) | 8'hC0));

    p_h_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cc_we && !(op_valid && op_code <= 4'd1)) |=> $stable(cc_out[4]));

    p_n_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> cc_out[2] == $past(res_out[7]));

    p_z_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> cc_out[1] == ($past(res_out) == 8'h00));

    p_c_logic_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && op_code >= 4'd4 && op_code <= 4'd7) |=> $stable(cc_out[0]));

    p_mask_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_we && !cc_we) |=> {cc_out[5], cc_out[3]} == $past(mask_wdata));

    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!cc_we && !mask_we && !(op_valid && op_code <= 4'd8)) |=> $stable(cc_out));
endmodule

bind alu_ccr_top alu_ccr_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_code    (op_code),
    .res_out    (res_out),
    .cc_we      (cc_we),
    .cc_wdata   (cc_wdata),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .cc_out     (cc_out)
);

// File: tb/tb_alu_ccr_top.sv
module tb_alu_ccr_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = '0;
    logic [7:0] acc_in = '0;
    logic [7:0] opnd_in = '0;
    logic [7:0] res_out;
    logic       res_we;
    logic       cc_we = 1'b0;
    logic [7:0] cc_wdata = '0;
    logic       mask_we = 1'b0;
    logic [1:0] mask_wdata = '0;
    logic [7:0] cc_out;
    logic       br_h_set, br_h_clr, br_minus, br_plus;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    alu_ccr_top dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic preset(input logic [7:0] v);
        @(negedge clk);
        op_valid = 1'b0; mask_we = 1'b0;
        cc_we = 1'b1; cc_wdata = v;
        @(negedge clk);
        cc_we = 1'b0;
    endtask

    task automatic chk_br(input string tag);
        chk({br_h_set, br_h_clr, br_minus, br_plus} ==
            {cc_out[4], ~cc_out[4], cc_out[2], ~cc_out[2]}, tag,
            {br_h_set, br_h_clr, br_minus, br_plus}, {cc_out[4], ~cc_out[4], cc_out[2], ~cc_out[2]});
    endtask

    task automatic run_op(input int op, input logic [7:0] a, input logic [7:0] b, input logic [7:0] pre);
        logic [8:0] s9;
        logic [4:0] n5;
        logic [7:0] er;
        logic [7:0] ecc;
        logic       ci, h, n, z, c, wb;
        preset(pre);
        ci = pre[0];
        h = pre[4]; c = pre[0]; n = pre[2]; z = pre[1];
        er = '0; wb = 1'b0;
        case (op)
            0, 1: begin
                s9 = 9'(a) + 9'(b) + ((op == 1) ? 9'(ci) : 9'd0);
                n5 = 5'(a[3:0]) + 5'(b[3:0]) + ((op == 1) ? 5'(ci) : 5'd0);
                er = s9[7:0]; c = s9[8]; h = n5[4];
            end
            2, 3, 8: begin
                s9 = 9'(a) - 9'(b) - ((op == 3) ? 9'(ci) : 9'd0);
                er = s9[7:0]; c = s9[8];
            end
            4: er = a & b;
            5: er = a | b;
            6: er = a ^ b;
            7: er = b;
            default: er = '0;
        endcase
        if (op <= 8) begin
            n = er[7]; z = (er == 8'h00); wb = (op != 8);
        end
        ecc = {2'b11, pre[5], h, pre[3], n, z, c};
        op_valid = 1'b1; op_code = 4'(op); acc_in = a; opnd_in = b;
        #1;
        chk(res_out == er, "R3 result", res_out, er);
        chk(res_we == wb, "R9 writeback", res_we, wb);
        @(negedge clk);
        op_valid = 1'b0;
        chk(cc_out[4] == ecc[4], (op <= 1) ? "R4 half carry" : "R5 H hold", cc_out[4], ecc[4]);
        chk(cc_out[2] == ecc[2], "R6 negative", cc_out[2], ecc[2]);
        chk(cc_out[1] == ecc[1], "R7 zero", cc_out[1], ecc[1]);
        chk(cc_out[0] == ecc[0], "R8 carry", cc_out[0], ecc[0]);
        chk(cc_out == ecc, (op > 8) ? "R12 no-op hold" : "R2 register", cc_out, ecc);
        chk_br("R11 branch");
    endtask

    initial begin
        #20;
        @(negedge clk);
        chk(cc_out == 8'hE8, "R1 reset value", cc_out, 8'hE8);
        chk_br("R11 branch at reset");
        rst_n = 1'b1;

        for (int op = 0; op < 16; op++) begin
            for (int i = 0; i < 16; i++) begin
                for (int j = 0; j < 16; j++) begin
                    for (int k = 0; k < 2; k++) begin
                        logic [7:0] pre;
                        pre = 8'((i * 7 + j * 3 + k * 29 + op) & 8'h3E) | 8'(k);
                        run_op(op, 8'((i * 37) & 255), 8'((j * 37) & 255), pre);
                    end
                end
            end
        end

        // R12: op_valid low leaves flags untouched
        preset(8'h15);
        op_code = 4'd0; acc_in = 8'hFF; opnd_in = 8'hFF; op_valid = 1'b0;
        @(negedge clk);
        chk(cc_out == 8'hD5, "R12 idle hold", cc_out, 8'hD5);

        // R10: mask write alone, then with a concurrent add
        preset(8'h17);
        mask_we = 1'b1; mask_wdata = 2'b10;
        @(negedge clk);
        mask_we = 1'b0;
        chk(cc_out == 8'hF7, "R10 mask write", cc_out, 8'hF7);
        preset(8'h00);
        mask_we = 1'b1; mask_wdata = 2'b01;
        op_valid = 1'b1; op_code = 4'd0; acc_in = 8'h08; opnd_in = 8'h08;
        @(negedge clk);
        mask_we = 1'b0; op_valid = 1'b0;
        chk(cc_out == 8'hD8, "R10 mask with add", cc_out, 8'hD8);

        // R2: full write wins over op and mask
        preset(8'h00);
        cc_we = 1'b1; cc_wdata = 8'h2A; mask_we = 1'b1; mask_wdata = 2'b00;
        op_valid = 1'b1; op_code = 4'd0; acc_in = 8'hFF; opnd_in = 8'h01;
        @(negedge clk);
        cc_we = 1'b0; mask_we = 1'b0; op_valid = 1'b0;
        chk(cc_out == 8'hEA, "R2 write priority", cc_out, 8'hEA);

        done = 1'b1;
    end

    initial begin
        for (int t = 0; t < 190000; t++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=0 expected=1");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule